// File: doc/BRIEF.md
# Latched Maskable Interrupt Controller

This block gathers interrupt events for a small 8-bit processor core from six sources: a fast timer tick (128 µs), a slow timer tick (1.024 ms), two USB endpoint events, a general-purpose I/O event and an external wake-up pin. Each source has its own pending latch. A latch is set on a rising edge of its source input and stays set until that interrupt is serviced or the block is reset.

An 8-bit enable register sits at I/O address 0x20. Software reads and writes it over a simple I/O bus. Enabled pending latches go through a fixed priority encoder. The block raises a registered interrupt request together with a 3-bit vector index.

The core pulses `ack` at an instruction boundary to accept the request. The block then services it in a fixed order. First it clears the whole enable register. On the next cycle it clears the latch of the accepted source. The vector index stays valid for the core to call through. Because every interrupt is masked on entry, a service routine must write the enable register again to allow further interrupts. This is also how nesting works.

Top module: `irqc_top`

## Requirements
- R1: Each source latch is set by a rising edge of its `src_in` bit. It stays set until that source is serviced or reset is asserted. A source input that is held high sets the latch only once.
- R2: A pending latch makes `irq` high only while its enable bit is 1. `irq` is registered, so it rises on the second clock edge after the enable write is presented: one edge for the register and one for `irq`.
- R3: The enable register is written when `io_wr` is high with `io_addr` = 0x20. A write to any other address leaves it unchanged. It reads back on `io_rd_data` while `io_rd` is high with `io_addr` = 0x20; any other address reads 0.
- R4: Enable bit positions are: bit 1 fast timer, bit 2 slow timer, bit 3 endpoint 0, bit 4 endpoint 1, bit 6 GPIO, bit 7 wake-up. Bits 5 and 0 ignore writes and always read 0.
- R5: Reset clears the enable register and all pending latches, and drives `irq` and `vec` to 0.
- R6: When several enabled latches are pending, the highest-priority one is served, in this order from highest: fast timer (vector 0), slow timer (1), endpoint 0 (2), endpoint 1 (3), GPIO (4), wake-up (5).
- R7: `ack` is accepted only when `irq` is high. Accepting it clears the whole enable register on that edge, and `irq` is low in the following cycle. An `ack` while `irq` is low has no effect.
- R8: On the clock edge after acceptance, only the accepted source's latch is cleared. Other latches stay pending, and they raise `irq` again once software re-enables them.
- R9: If a new rising edge on a source arrives in the same cycle that its latch is being cleared, the latch stays set.
- R10: `vec` does not change while `irq` stays high, even if a higher-priority request becomes pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_in | input | 6 | Source event lines (bit 0 fast timer, 1 slow timer, 2 endpoint 0, 3 endpoint 1, 4 GPIO, 5 wake-up) |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | I/O read strobe |
| io_rd_data | output | 8 | I/O read data (0 unless reading the enable register) |
| ack | input | 1 | Interrupt acknowledge from the core, one cycle |
| irq | output | 1 | Registered interrupt request |
| vec | output | 3 | Vector index of the request |

## Verification
The bench targets these corner cases:

- **Write order on acknowledge.** A source edge lands in exactly the cycle its latch is cleared. If clear won over set, that event would be lost.
- **Held vector.** A higher-priority request arrives while `irq` is already high. A vector that was not held would switch sources under the core.
- **Partial clearing.** Several sources are pending at once. A block that cleared more than the accepted latch would drop requests.
- **Held source line.** A source stays high through its service. A level-sensitive latch would re-fire after re-enable.

It also checks the reserved enable bits, writes to a foreign address, an `ack` with no request pending, and a reset in the middle of activity.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [0:0] {
    SVC_IDLE  = 1'b0,
    SVC_CLEAR = 1'b1
  } svc_state_e;

  // Position of a source's enable bit in the enable register.
  function automatic int en_pos(input int src);
    case (src)
      0:       return 1;
      1:       return 2;
      2:       return 3;
      3:       return 4;
      4:       return 6;
      default: return 7;
    endcase
  endfunction

endpackage

// File: rtl/irqc_enable.sv
module irqc_enable #(
  parameter int                    ADDR_W  = 8,
  parameter int                    DATA_W  = 8,
  parameter logic [ADDR_W-1:0]     EN_ADDR = 8'h20,
  parameter logic [DATA_W-1:0]     USED    = 8'hDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_all,
  output logic [DATA_W-1:0] en_q
);

  logic              hit;
  logic              ld;
  logic [DATA_W-1:0] en_d;

  always_comb begin
    hit = wr && (addr == EN_ADDR);
    ld  = hit || clr_all;
    if (clr_all) en_d = '0;          // acknowledge wins over a write
    else         en_d = wdata & USED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (ld) en_q <= en_d;
  end

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] evt,
  output logic [NSRC-1:0] pend_q
);

  logic [NSRC-1:0] src_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_prev_q <= '0;
    else        src_prev_q <= src_in;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_lat
    logic pend_d;
    logic ld;

    always_comb begin
      evt[g] = src_in[g] & ~src_prev_q[g];
      ld     = evt[g] | clr[g];
      pend_d = evt[g];               // set dominates a simultaneous clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pend_q[g] <= 1'b0;
      else if (ld) pend_q[g] <= pend_d;
    end
  end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NSRC  = 6,
  parameter int VEC_W = 3
) (
  input  logic [NSRC-1:0]  req,
  output logic             any,
  output logic [VEC_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    // scan from lowest priority so the last match (lowest index) wins
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = VEC_W'(i);
      end
    end
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int                NSRC    = 6,
  parameter int                VEC_W   = 3,
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rd_data,
  input  logic              ack,
  output logic              irq,
  output logic [VEC_W-1:0]  vec
);

  import irqc_pkg::*;

  function automatic logic [DATA_W-1:0] used_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[en_pos(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] EN_USED = used_mask();

  logic [DATA_W-1:0] en_q;
  logic [NSRC-1:0]   pend_q;
  logic [NSRC-1:0]   evt;
  logic [NSRC-1:0]   req;
  logic [NSRC-1:0]   clr_vec;
  logic              req_any;
  logic [VEC_W-1:0]  req_idx;

  svc_state_e        state_q, state_d;
  logic [VEC_W-1:0]  svc_q, svc_d;
  logic              irq_q, irq_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic              take;
  logic              clr_phase;
  logic              vec_ld;

  irqc_enable #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .EN_ADDR(EN_ADDR),
    .USED   (EN_USED)
  ) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (io_wr),
    .addr   (io_addr),
    .wdata  (io_wdata),
    .clr_all(take),
    .en_q   (en_q)
  );

  irqc_pending #(.NSRC(NSRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .src_in(src_in),
    .clr   (clr_vec),
    .evt   (evt),
    .pend_q(pend_q)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_req
    assign req[g]     = pend_q[g] & en_q[en_pos(g)];
    assign clr_vec[g] = clr_phase && (svc_q == VEC_W'(g));
  end

  irqc_prio #(.NSRC(NSRC), .VEC_W(VEC_W)) u_prio (
    .req(req),
    .any(req_any),
    .idx(req_idx)
  );

  // service sequencer: accept -> mask all -> clear serviced latch
  always_comb begin
    take      = ack && irq_q && (state_q == SVC_IDLE);
    clr_phase = (state_q == SVC_CLEAR);
    state_d   = state_q;
    case (state_q)
      SVC_IDLE:  if (take) state_d = SVC_CLEAR;
      SVC_CLEAR: state_d = SVC_IDLE;
      default:   state_d = SVC_IDLE;
    endcase
    svc_d  = vec_q;
    irq_d  = (state_q == SVC_IDLE) && !take && req_any;
    vec_ld = !irq_q && (state_q == SVC_IDLE);
    vec_d  = req_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SVC_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    svc_q <= '0;
    else if (take) svc_q <= svc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_ld) vec_q <= vec_d;
  end

  assign irq        = irq_q;
  assign vec        = vec_q;
  assign io_rd_data = (io_rd && (io_addr == EN_ADDR)) ? en_q : '0;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NSRC   = 6,
  parameter int VEC_W  = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic              irq,
  input logic [VEC_W-1:0]  vec,
  input logic [DATA_W-1:0] io_rd_data,
  input logic [DATA_W-1:0] en_q,
  input logic [NSRC-1:0]   pend_q,
  input logic [NSRC-1:0]   evt,
  input logic              clr_phase,
  input logic [VEC_W-1:0]  svc
);

  // R7
  ack_masks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !clr_phase) |=> (en_q == '0));

  // R7
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !clr_phase) |=> !irq);

  // R8
  latch_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_phase && !evt[svc]) |=> !pend_q[svc]);

  // R9
  collide_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_phase && evt[svc]) |=> pend_q[svc]);

  // R10
  vec_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(irq)) |-> $stable(vec));

  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_data[5] == 1'b0) && (io_rd_data[0] == 1'b0));

  // R1
  for (genvar g = 0; g < NSRC; g++) begin : g_hold
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && !clr_phase) |=> pend_q[g]);
  end

endmodule

bind irqc_top irqc_chk #(
  .NSRC  (NSRC),
  .VEC_W (VEC_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack       (ack),
  .irq       (irq),
  .vec       (vec),
  .io_rd_data(io_rd_data),
  .en_q      (en_q),
  .pend_q    (pend_q),
  .evt       (evt),
  .clr_phase (clr_phase),
  .svc       (svc_q)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] src_in;
  logic [7:0] io_addr;
  logic       io_wr;
  logic [7:0] io_wdata;
  logic       io_rd;
  logic [7:0] io_rd_data;
  logic       ack;
  logic       irq;
  logic [2:0] vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;   // 50 MHz

  irqc_top uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .io_rd     (io_rd),
    .io_rd_data(io_rd_data),
    .ack       (ack),
    .irq       (irq),
    .vec       (vec)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr_en(input logic [7:0] a, input logic [7:0] d);
    io_addr  = a;
    io_wdata = d;
    io_wr    = 1'b1;
    step(1);
    io_wr    = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    io_addr = a;
    io_rd   = 1'b1;
    @(negedge clk);
    chk(tag, io_rd_data, exp);
    step(1);
    io_rd   = 1'b0;
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    @(negedge clk);
    chk(tag, {7'd0, irq}, {7'd0, exp});
    step(1);
  endtask

  task automatic vec_chk(input string tag, input logic [2:0] exp);
    @(negedge clk);
    chk(tag, {5'd0, vec}, {5'd0, exp});
    step(1);
  endtask

  task automatic pulse(input int i);
    src_in[i] = 1'b1;
    step(1);
    src_in[i] = 1'b0;
  endtask

  // driver: pushes the expected vector, then acknowledges
  task automatic service(input string tag, input logic [2:0] exp, input int collide);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    if (collide >= 0) src_in[collide] = 1'b1;   // edge lands in the clear cycle
    step(1);
    if (collide >= 0) src_in[collide] = 1'b0;
  endtask

  // monitor: compares the vector presented when ack is taken
  always @(negedge clk) begin
    if (rst_n && ack && irq) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R7 unexpected acknowledge actual=%0d expected=none", vec);
      end else begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {5'd0, vec}, {5'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_in = '0; io_addr = '0; io_wr = 1'b0;
    io_wdata = '0; io_rd = 1'b0; ack = 1'b0;
    step(3);
    rst_n = 1'b1;

    // R5 reset state
    irq_chk("R5 irq after reset", 1'b0);
    vec_chk("R5 vec after reset", 3'd0);
    rd_chk("R5 enable after reset", 8'h20, 8'h00);

    // R4 reserved bits, R3 address decode
    wr_en(8'h20, 8'hFF);
    rd_chk("R4 reserved bits", 8'h20, 8'hDE);
    wr_en(8'h21, 8'h00);
    rd_chk("R3 foreign write", 8'h20, 8'hDE);
    rd_chk("R3 foreign read", 8'h21, 8'h00);
    wr_en(8'h20, 8'h00);

    // R1 latch held while masked, R2 one-cycle registered request
    pulse(0);
    step(2);
    irq_chk("R2 masked", 1'b0);
    wr_en(8'h20, 8'h02);
    irq_chk("R2 registered delay", 1'b0);
    irq_chk("R1 latch held", 1'b1);
    vec_chk("R6 fast timer vector", 3'd0);

    // R7 masking on acknowledge, R8 latch cleared
    service("R6 vec fast timer", 3'd0, -1);
    rd_chk("R7 enable cleared", 8'h20, 8'h00);
    wr_en(8'h20, 8'h02);
    step(2);
    irq_chk("R8 latch cleared", 1'b0);

    // R6 priority, R8 others remain pending, nesting via re-enable
    pulse(3);
    pulse(4);
    pulse(1);
    wr_en(8'h20, 8'hDE);
    step(2);
    service("R6 vec slow timer", 3'd1, -1);
    wr_en(8'h20, 8'hDE);
    step(2);
    service("R8 vec endpoint 1", 3'd3, -1);
    wr_en(8'h20, 8'hDE);
    step(2);
    service("R8 vec gpio", 3'd4, -1);
    wr_en(8'h20, 8'hDE);
    step(2);
    irq_chk("R8 all served", 1'b0);

    // R10 vector held while irq high
    wr_en(8'h20, 8'h40);
    pulse(4);
    step(2);
    pulse(0);
    wr_en(8'h20, 8'hDE);
    step(2);
    vec_chk("R10 vector held", 3'd4);
    service("R10 vec held gpio", 3'd4, -1);
    wr_en(8'h20, 8'hDE);
    step(2);
    service("R6 vec after hold", 3'd0, -1);

    // R1 held-high source fires once
    src_in[5] = 1'b1;
    step(1);
    wr_en(8'h20, 8'h80);
    step(2);
    service("R1 vec wakeup", 3'd5, -1);
    wr_en(8'h20, 8'h80);
    step(3);
    irq_chk("R1 level does not refire", 1'b0);
    src_in[5] = 1'b0;

    // R9 event colliding with clear
    pulse(2);
    wr_en(8'h20, 8'h08);
    step(2);
    service("R9 vec endpoint 0", 3'd2, 2);
    wr_en(8'h20, 8'h08);
    step(2);
    irq_chk("R9 event kept", 1'b1);
    service("R9 vec second", 3'd2, -1);

    // R7 ack without request is ignored
    wr_en(8'h20, 8'h90);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    rd_chk("R7 stray ack", 8'h20, 8'h90);

    // R5 reset mid-activity
    wr_en(8'h20, 8'h04);
    pulse(1);
    step(2);
    irq_chk("R5 pre-reset irq", 1'b1);
    rst_n = 1'b0;
    step(1);
    rst_n = 1'b1;
    irq_chk("R5 irq reset", 1'b0);
    rd_chk("R5 enable reset", 8'h20, 8'h00);
    wr_en(8'h20, 8'h04);
    step(2);
    irq_chk("R5 latch reset", 1'b0);

    chk("R7 all acks observed", 8'(exp_q.size()), 8'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule